// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block lets a core reach external memory or I/O over a narrow shared bus. The low address byte and the data byte travel on the same eight lines at different times. The high address byte has its own dedicated output port. The core presents a 16-bit address, a direction, optional write data and an extended-timing flag. It asserts a request while the controller reports idle, then waits for a one-cycle completion pulse. For reads, the captured byte is returned alongside that pulse.

Every transaction runs through a fixed sequence of phases, each counted in clock cycles:

1. An address setup phase.
2. An address-strobe-low phase.
3. A turnaround phase in which the shared lines are released.
4. A data-strobe-low phase. Its length depends on the direction and the extended flag.
5. A single recovery cycle.

All phase lengths are parameters. The default sequence takes 8 clocks for a normal read and 7 for a normal write. The extended flag adds 2 clocks to either.

Top module: `mbus_master`

## Requirements
- R1: While reset is asserted and right after it, both strobes are high, the shared-line output enable is 0, `done` is 0, `idle` is 1 and `bus_rw` is 1.
- R2: A request is taken only in a cycle where `idle` is 1. `idle` drops in the next cycle. A request made while busy has no effect on the transaction in flight, and it does not start another one.
- R3: For the first 3 cycles of a transaction, the low address byte is driven on `bus_ad_out` with the enable set, and `bus_hi` carries address bits 15:8. `bus_as_n` is high in cycles 0 and 1 and low in cycle 2.
- R4: Cycle 3 is a turnaround cycle. Both strobes are high and the output enable is 0.
- R5: `bus_ds_n` goes low from cycle 4 onward. It stays low for 3 cycles on a read or 2 cycles on a write, plus 2 more cycles when the extended flag is set.
- R6: On a write, the write byte is driven with the enable set for the whole data-strobe phase and the recovery cycle after it.
- R7: On a read, the enable is 0 during the data-strobe phase. `rdata` is the `bus_ad_in` value present in the last data-strobe-low cycle, sampled at the edge where `bus_ds_n` rises.
- R8: One recovery cycle follows the data-strobe phase. In it both strobes are high and `done` is 1 for exactly that cycle. `idle` returns in the next cycle.
- R9: `bus_rw` is 1 for a read and 0 for a write, from cycle 0 through the recovery cycle. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Transaction request, taken when `idle` is 1 |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_ext | input | 1 | Stretch the data-strobe phase by 2 clocks |
| req_addr | input | 16 | Transaction address |
| req_wdata | input | 8 | Write byte |
| idle | output | 1 | Controller can take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |
| bus_hi | output | 8 | High address byte port |
| bus_ad_out | output | 8 | Shared address/data lines, outgoing value |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | 8 | Shared address/data lines, incoming value |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |

## Verification
The embedded properties check the following on every cycle:

- The data strobe only falls after a cycle with the address strobe high and the shared lines released.
- The address stays stable while the address strobe is low.
- Write data is still driven in the cycle after the data strobe rises.
- The direction line holds steady through the strobe and recovery cycles.
- A read never drives the shared lines while the data strobe is low.
- `done` never lasts two cycles.

The exact phase lengths, the effect of the extended flag, and the choice of which input byte is captured can only be shown by the bench's cycle-by-cycle comparison. The same applies to ignoring a request while busy. The bench changes `bus_ad_in` every cycle so that a capture one cycle early or late is caught.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_ASTB  = 3'd2,
    PH_FLOAT = 3'd3,
    PH_DSTB  = 3'd4,
    PH_RECOV = 3'd5
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_CYC = 2,
  parameter int AS_CYC   = 1,
  parameter int FLT_CYC  = 1,
  parameter int RD_CYC   = 3,
  parameter int WR_CYC   = 2,
  parameter int EXT_CYC  = 2,
  parameter int REC_CYC  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   op_rd,
  input  logic   op_ext,
  output phase_e phase,
  output logic   ds_last
);
  localparam int DS_MAX = imax(RD_CYC, WR_CYC) + EXT_CYC;
  localparam int MAXC   = imax(imax(imax(ADDR_CYC, AS_CYC), imax(FLT_CYC, REC_CYC)), DS_MAX);
  localparam int CW     = $clog2(MAXC + 1);

  phase_e        ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] ds_len;

  always_comb begin
    ds_len = op_rd ? CW'(RD_CYC) : CW'(WR_CYC);
    if (op_ext) ds_len = ds_len + CW'(EXT_CYC);
  end

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_n  = PH_ADDR;
        cnt_n = CW'(ADDR_CYC - 1);
      end
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end else begin
      unique case (ph_q)
        PH_ADDR:  begin ph_n = PH_ASTB;  cnt_n = CW'(AS_CYC - 1);  end
        PH_ASTB:  begin ph_n = PH_FLOAT; cnt_n = CW'(FLT_CYC - 1); end
        PH_FLOAT: begin ph_n = PH_DSTB;  cnt_n = ds_len - 1'b1;    end
        PH_DSTB:  begin ph_n = PH_RECOV; cnt_n = CW'(REC_CYC - 1); end
        default:  begin ph_n = PH_IDLE;  cnt_n = '0;               end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
    end
  end

  assign phase   = ph_q;
  assign ds_last = (ph_q == PH_DSTB) && (cnt_q == '0);

  // R2: the address phase is entered only from idle
  a_r2_addr_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ADDR && $past(ph_q) != PH_ADDR) |-> $past(ph_q) == PH_IDLE);
  // R4: turnaround always sits between address strobe and data strobe
  a_r4_float_before_ds: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DSTB && $past(ph_q) != PH_DSTB) |-> $past(ph_q) == PH_FLOAT);
endmodule

// File: rtl/mbus_dp.sv
module mbus_dp
  import mbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int HW = 8,
  localparam int AW = DW + HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_rd,
  input  logic          req_ext,
  input  phase_e        phase,
  input  logic          ds_last,
  input  logic [DW-1:0] ad_in,
  output logic          op_rd,
  output logic          op_ext,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [HW-1:0] hi_addr,
  output logic          rw,
  output logic          as_n,
  output logic          ds_n,
  output logic          done,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_q;
  logic          rdop_q, ext_q;
  logic          cap_en;
  logic          addr_ph, data_ph;

  assign cap_en = ds_last && rdop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
      rdop_q <= 1'b1;
      ext_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
      rdop_q <= req_rd;
      ext_q  <= req_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_en) rd_q <= ad_in;
  end

  assign addr_ph = (phase == PH_ADDR) || (phase == PH_ASTB);
  assign data_ph = (phase == PH_DSTB) || (phase == PH_RECOV);

  assign op_rd   = rdop_q;
  assign op_ext  = ext_q;
  assign as_n    = (phase != PH_ASTB);
  assign ds_n    = (phase != PH_DSTB);
  assign ad_oe   = addr_ph || (data_ph && !rdop_q);
  assign ad_out  = addr_ph ? addr_q[DW-1:0] : wd_q;
  assign hi_addr = addr_q[AW-1:DW];
  assign rw      = (phase == PH_IDLE) ? 1'b1 : rdop_q;
  assign done    = (phase == PH_RECOV);
  assign rdata   = rd_q;

  // R5: data strobe falls only after strobe high and lines released
  a_r5_ds_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n) |-> ($past(as_n) && !$past(ad_oe)));
  // R3: address held on the lines while the address strobe is low
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> (ad_oe && $stable(ad_out)));
  // R6: write data still driven after data strobe rises
  a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ds_n) && !rw) |-> (ad_oe && $stable(ad_out)));
  // R7: reads never drive the shared lines under the data strobe
  a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && rw) |-> !ad_oe);
  // R9: direction steady through strobe and recovery
  a_r9_rw_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n || done) |-> $stable(rw));
  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mbus_master.sv
module mbus_master
  import mbus_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HW       = 8,
  parameter int ADDR_CYC = 2,
  parameter int AS_CYC   = 1,
  parameter int FLT_CYC  = 1,
  parameter int RD_CYC   = 3,
  parameter int WR_CYC   = 2,
  parameter int EXT_CYC  = 2,
  parameter int REC_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_rd,
  input  logic             req_ext,
  input  logic [DW+HW-1:0] req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             idle,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic [HW-1:0]    bus_hi,
  output logic [DW-1:0]    bus_ad_out,
  output logic             bus_ad_oe,
  input  logic [DW-1:0]    bus_ad_in,
  output logic             bus_as_n,
  output logic             bus_ds_n,
  output logic             bus_rw
);
  logic [1:0] rsync_q;
  logic       rst_i_n;
  phase_e     phase;
  logic       ds_last, op_rd, op_ext, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  assign idle   = (phase == PH_IDLE);
  assign accept = req && idle;

  mbus_seq #(
    .ADDR_CYC(ADDR_CYC), .AS_CYC(AS_CYC), .FLT_CYC(FLT_CYC),
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .EXT_CYC(EXT_CYC), .REC_CYC(REC_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(accept),
    .op_rd(op_rd), .op_ext(op_ext), .phase(phase), .ds_last(ds_last)
  );

  mbus_dp #(.DW(DW), .HW(HW)) u_dp (
    .clk(clk), .rst_n(rst_i_n), .accept(accept),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rd(req_rd), .req_ext(req_ext),
    .phase(phase), .ds_last(ds_last), .ad_in(bus_ad_in),
    .op_rd(op_rd), .op_ext(op_ext),
    .ad_out(bus_ad_out), .ad_oe(bus_ad_oe), .hi_addr(bus_hi), .rw(bus_rw),
    .as_n(bus_as_n), .ds_n(bus_ds_n), .done(done), .rdata(rdata)
  );

  // R9: strobes never overlap at the pins
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(!bus_as_n && !bus_ds_n));
  // R2: a taken request clears idle on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept |=> !idle);
endmodule

// File: tb/sim_mbus_master.sv
module sim_mbus_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_rd, req_ext;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, ad_in;
  logic        idle, done, ad_oe, as_n, ds_n, rw;
  logic [7:0]  rdata, hi, ad_out;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int       mt = -1;
  bit       m_rd, m_ext;
  bit [15:0] m_addr;
  bit [7:0] m_wd, m_rdata;
  int       dl;

  always #5 clk = ~clk;

  mbus_master u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd), .req_ext(req_ext),
    .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle), .done(done),
    .rdata(rdata), .bus_hi(hi), .bus_ad_out(ad_out), .bus_ad_oe(ad_oe),
    .bus_ad_in(ad_in), .bus_as_n(as_n), .bus_ds_n(ds_n), .bus_rw(rw)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference, advanced on the active edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) mt = -1;
    else if (mt < 0) begin
      if (req) begin
        mt = 0; m_rd = req_rd; m_ext = req_ext; m_addr = req_addr; m_wd = req_wdata;
        dl = (m_rd ? 3 : 2) + (m_ext ? 2 : 0);
      end
    end else begin
      if (mt == 3 + dl && m_rd) m_rdata = ad_in;
      if (mt == 4 + dl) mt = -1;
      else mt++;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_as, e_ds, e_oe, e_done, e_rw, addr_ph, ds_ph, rec_ph;
      addr_ph = (mt >= 0 && mt <= 2);
      ds_ph   = (mt >= 4 && mt < 4 + dl);
      rec_ph  = (mt >= 0 && mt == 4 + dl);
      e_as    = !(mt == 2);
      e_ds    = !ds_ph;
      e_oe    = addr_ph || ((ds_ph || rec_ph) && !m_rd);
      e_done  = rec_ph;
      e_rw    = (mt < 0) ? 1'b1 : m_rd;
      chk(idle == (mt < 0), "R2 idle", idle, mt < 0);
      chk(as_n == e_as, "R3 as_n", as_n, e_as);
      chk(ds_n == e_ds, "R5 ds_n", ds_n, e_ds);
      chk(ad_oe == e_oe, (mt == 3) ? "R4 oe turnaround" : (m_rd ? "R7 oe" : "R6 oe"), ad_oe, e_oe);
      chk(done == e_done, "R8 done", done, e_done);
      chk(rw == e_rw, "R9 rw", rw, e_rw);
      chk(!(!as_n && !ds_n), "R9 strobe overlap", {as_n, ds_n}, 2'b11);
      if (mt >= 0) chk(hi == m_addr[15:8], "R3 hi addr", hi, m_addr[15:8]);
      if (addr_ph) chk(ad_out == m_addr[7:0], "R3 low addr", ad_out, m_addr[7:0]);
      if ((ds_ph || rec_ph) && !m_rd) chk(ad_out == m_wd, "R6 write data", ad_out, m_wd);
      if (rec_ph && m_rd) chk(rdata == m_rdata, "R7 rdata", rdata, m_rdata);
      ad_in <= 8'h3C ^ 8'(cyc * 7);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (!idle);
  endtask

  task automatic txn(input bit rd, input bit ext, input bit [15:0] a, input bit [7:0] wd);
    wait_idle();
    req = 1; req_rd = rd; req_ext = ext; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    rst_n = 0; req = 0; req_rd = 0; req_ext = 0; req_addr = '0; req_wdata = '0; ad_in = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(as_n && ds_n, "R1 strobes", {as_n, ds_n}, 2'b11);
    chk(!ad_oe, "R1 oe", ad_oe, 0);
    chk(!done, "R1 done", done, 0);
    chk(idle, "R1 idle", idle, 1);
    chk(rw, "R1 rw", rw, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(idle && as_n && ds_n && !ad_oe, "R1 after release", {idle, as_n, ds_n, ad_oe}, 4'b1110);

    txn(1, 0, 16'hA512, 8'h00);      // R7 normal read
    txn(0, 0, 16'h1234, 8'h5A);      // R6 normal write
    txn(1, 1, 16'hFF01, 8'h00);      // R5 extended read
    txn(0, 1, 16'h00FE, 8'hC3);      // R5 extended write
    // R2: requests while busy are ignored
    txn(0, 0, 16'h8001, 8'h99);
    repeat (3) begin
      req = 1; req_rd = 1; req_ext = 1; req_addr = 16'h4444; req_wdata = 8'h11;
      @(negedge clk);
    end
    req = 0;
    // back-to-back: request held high across the idle return
    wait_idle();
    req = 1; req_rd = 1; req_ext = 0; req_addr = 16'h7E7E;
    @(negedge clk);
    req_rd = 0; req_addr = 16'h0101; req_wdata = 8'hA0;
    while (!idle) @(negedge clk);
    @(negedge clk);
    req = 0;
    for (int i = 0; i < 6; i++) txn(i[0], i[1], 16'(16'h3000 + i * 16'h0111), 8'(8'h20 + i));
    wait_idle();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule